// File: doc/BRIEF.md
# Cross-Domain Register Access Bridge

This block gives a processor running on a fast interface clock a way to reach registers that sit on a slow, free-running real-time clock. The two clocks are unrelated. On the processor side the bridge has four 32-bit staging registers: a control/busy word, an access-enable word, a target address and a data word. Software fills the staging registers in any order and then writes the control register to launch one access.

The launch is passed to the slow domain by flipping a request toggle. A two-flop synchronizer carries the toggle across, and an acknowledge toggle comes back through its own two-flop synchronizer. While the handshake is open, the staging registers are frozen, so the slow side can sample them directly. In the slow domain the bridge drives one single-cycle access onto a plain register bus. For a read, it captures the returned word in that same cycle.

When the acknowledge arrives, the processor side moves any read result into its data register. On the same edge it drops the busy flag, so the data register is already valid on the first poll that sees busy clear.

Top module: `xdom_reg_bridge`

## Requirements
- R1: After reset, the control register reads 0 and the data register reads 0, and no slow-bus strobe is issued until a transfer is started.
- R2: Writing a value with bit 0 set to the control register (offset 0x0) while idle starts exactly one slow-bus access.
- R3: The control register reads 1 from the cycle after an accepted start until the transfer has completed, and reads 0 afterwards.
- R4: With enable register (offset 0x4) value 0x00, the access is a read. Once busy clears, the data register (offset 0xC) holds the word stored at the target address.
- R5: With enable value 0xF1, the full 32-bit data register contents are written to the target address (offset 0x8 register).
- R6: Enable bit 0 is the write flag and enable bits 7:4 are byte enables for data bytes 0 to 3. Target bytes whose enable is clear keep their value.
- R7: The address, enable and data registers can be loaded in any order and read back unchanged while idle.
- R8: A control-register write while busy is ignored. No extra access is issued, and the transfer in flight completes normally.
- R9: Writes to the address, enable or data register while busy are ignored, and the launched values are kept.
- R10: The first read of the data register after busy is observed clear returns the completed read's result.
- R11: Writing a control value with bit 0 clear starts nothing.
- R12: Each slow-bus access holds the strobe for exactly one slow-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor interface clock |
| cpu_rst_n | input | 1 | Synchronous active-low reset, processor domain |
| cpu_sel | input | 1 | Register access select |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Byte offset of the staging register |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data (combinational from the selected register) |
| rtc_clk | input | 1 | Slow real-time clock |
| rtc_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| rtc_strobe | output | 1 | Slow-bus access strobe, one cycle |
| rtc_write | output | 1 | Slow-bus access is a write |
| rtc_be | output | 4 | Slow-bus byte enables |
| rtc_addr | output | 16 | Slow-bus target address |
| rtc_wdata | output | 32 | Slow-bus write data |
| rtc_rdata | input | 32 | Slow-bus read data, sampled in the strobe cycle |

## Verification
The main function is exercised four ways. Plain reads of preloaded words, a full-word write with enable 0xF1, and a sparse byte-enable write over a known pattern show that the write flag and the byte-lane mapping are decoded separately. Starts and staging writes issued in the middle of a transfer show whether the in-flight request stays frozen or is corrupted. A counted strobe total and a check for back-to-back strobes show that each start produces exactly one single-cycle access. Polling the data register on the first idle read shows that read data lands before busy drops.

// File: rtl/crbr_pkg.sv
// Package: shared offsets, field positions and register select type for the
// cross-domain register bridge. Assumes 32-bit processor-side registers.
package crbr_pkg;
    localparam int OFFS_W     = 4;   // byte offset width of the staging map
    localparam int EN_WR_BIT  = 0;   // write flag position in enable register
    localparam int EN_BE_LSB  = 4;   // first byte-enable bit in enable register

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,   // offset 0x0
        SEL_EN   = 2'd1,   // offset 0x4
        SEL_ADDR = 2'd2,   // offset 0x8
        SEL_DATA = 2'd3    // offset 0xC
    } reg_sel_e;
endpackage

// File: rtl/crbr_sync2.sv
// Module: two-flop synchronizer for slowly changing single-bit (toggle) signals.
// Assumes the input changes at most once per several destination cycles.
module crbr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/crbr_cpu_regs.sv
// Module: processor-domain staging registers, start logic and completion.
// Assumes the slow side samples tgt_* only while busy is set, and presents
// rd_hold stable from before the acknowledge toggle until the next request.
module crbr_cpu_regs
    import crbr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int TAW = 16,
    parameter int ENW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [OFFS_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              req_tgl,
    input  logic              ack_tgl_async,
    input  logic [DW-1:0]     rd_hold,
    output logic [TAW-1:0]    tgt_addr,
    output logic [ENW-1:0]    tgt_en,
    output logic [DW-1:0]     tgt_wdata
);
    reg_sel_e    rsel;
    logic        busy;
    logic        ack_s;
    logic        ack_seen;
    logic        done;
    logic        wr_ctrl, wr_stage_ok, start_ok;

    assign rsel        = reg_sel_e'(addr[OFFS_W-1:2]);
    assign wr_ctrl     = sel && wr && (rsel == SEL_CTRL);
    assign start_ok    = wr_ctrl && wdata[0] && !busy;
    assign wr_stage_ok = sel && wr && !busy;
    assign done        = busy && (ack_s != ack_seen);

    crbr_sync2 #(.W(1)) i_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ack_tgl_async),
        .q_sync  (ack_s)
    );

    // Start, busy and acknowledge tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            req_tgl  <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            ack_seen <= ack_s;
            if (start_ok) begin
                busy    <= 1'b1;
                req_tgl <= ~req_tgl;
            end else if (done) begin
                busy    <= 1'b0;
            end
        end
    end

    // Staging registers; data also takes the read result at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr  <= '0;
            tgt_en    <= '0;
            tgt_wdata <= '0;
        end else begin
            if (wr_stage_ok && rsel == SEL_ADDR) tgt_addr <= wdata[TAW-1:0];
            if (wr_stage_ok && rsel == SEL_EN)   tgt_en   <= wdata[ENW-1:0];
            if (done && !tgt_en[EN_WR_BIT])
                tgt_wdata <= rd_hold;
            else if (wr_stage_ok && rsel == SEL_DATA)
                tgt_wdata <= wdata;
        end
    end

    // Read-back multiplexer
    always_comb begin
        rdata = '0;
        unique case (rsel)
            SEL_CTRL: rdata = DW'(busy);
            SEL_EN:   rdata = DW'(tgt_en);
            SEL_ADDR: rdata = DW'(tgt_addr);
            SEL_DATA: rdata = tgt_wdata;
        endcase
    end

    // R3: an accepted start raises busy and flips the request
    assert_start_raises_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[0] && !busy) |=> (busy && req_tgl != $past(req_tgl)));
    // R8: a control write while busy leaves the request untouched
    assert_ignore_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctrl) |=> $stable(req_tgl));
    // R9: staging values stay frozen while a transfer is open
    assert_stage_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel && wr) |=> ($stable(tgt_addr) && $stable(tgt_en)));
    // R1: when idle, the handshake is closed
    assert_idle_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (req_tgl == ack_seen));
endmodule

// File: rtl/crbr_slow_engine.sv
// Module: slow-domain engine. Detects a request toggle, issues one single-cycle
// bus access, captures read data and returns an acknowledge toggle.
// Assumes the source address/enable/data are stable while the request is open.
module crbr_slow_engine
    import crbr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int TAW = 16,
    parameter int ENW = 8,
    parameter int BEW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_tgl_async,
    input  logic [TAW-1:0] src_addr,
    input  logic [ENW-1:0] src_en,
    input  logic [DW-1:0]  src_wdata,
    output logic           bus_strobe,
    output logic           bus_write,
    output logic [BEW-1:0] bus_be,
    output logic [TAW-1:0] bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic [DW-1:0]  rd_hold,
    output logic           ack_tgl
);
    logic req_s;
    logic req_seen;

    crbr_sync2 #(.W(1)) i_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_tgl_async),
        .q_sync  (req_s)
    );

    // Launch one access on a new request, retire it one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen   <= 1'b0;
            ack_tgl    <= 1'b0;
            bus_strobe <= 1'b0;
            bus_write  <= 1'b0;
            bus_be     <= '0;
            bus_addr   <= '0;
            bus_wdata  <= '0;
            rd_hold    <= '0;
        end else if (bus_strobe) begin
            bus_strobe <= 1'b0;
            ack_tgl    <= ~ack_tgl;
            if (!bus_write) rd_hold <= bus_rdata;
        end else if (req_s != req_seen) begin
            req_seen   <= req_s;
            bus_strobe <= 1'b1;
            bus_write  <= src_en[EN_WR_BIT];
            bus_be     <= src_en[EN_BE_LSB +: BEW];
            bus_addr   <= src_addr;
            bus_wdata  <= src_wdata;
        end
    end

    // R12: the strobe never lasts beyond one slow cycle
    assert_single_cycle_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !bus_strobe);
    // R2: every access is answered by exactly one acknowledge flip
    assert_ack_follows_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> (ack_tgl != $past(ack_tgl)));
    // R2: no acknowledge flip without an access
    assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> $stable(ack_tgl));
endmodule

// File: rtl/xdom_reg_bridge.sv
// Module: top of the cross-domain register bridge. Joins the processor-side
// staging registers to the slow-domain engine with a toggle handshake.
// Assumes the two clocks are unrelated; multi-bit paths are quasi-static.
module xdom_reg_bridge
    import crbr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int TAW = 16
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [OFFS_W-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    output logic              rtc_strobe,
    output logic              rtc_write,
    output logic [DW/8-1:0]   rtc_be,
    output logic [TAW-1:0]    rtc_addr,
    output logic [DW-1:0]     rtc_wdata,
    input  logic [DW-1:0]     rtc_rdata
);
    localparam int BEW = DW / 8;
    localparam int ENW = EN_BE_LSB + BEW;

    logic           req_tgl, ack_tgl;
    logic [DW-1:0]  rd_hold;
    logic [TAW-1:0] tgt_addr;
    logic [ENW-1:0] tgt_en;
    logic [DW-1:0]  tgt_wdata;

    crbr_cpu_regs #(.DW(DW), .TAW(TAW), .ENW(ENW)) i_cpu_regs (
        .clk           (cpu_clk),
        .rst_n         (cpu_rst_n),
        .sel           (cpu_sel),
        .wr            (cpu_wr),
        .addr          (cpu_addr),
        .wdata         (cpu_wdata),
        .rdata         (cpu_rdata),
        .req_tgl       (req_tgl),
        .ack_tgl_async (ack_tgl),
        .rd_hold       (rd_hold),
        .tgt_addr      (tgt_addr),
        .tgt_en        (tgt_en),
        .tgt_wdata     (tgt_wdata)
    );

    crbr_slow_engine #(.DW(DW), .TAW(TAW), .ENW(ENW), .BEW(BEW)) i_slow_engine (
        .clk           (rtc_clk),
        .rst_n         (rtc_rst_n),
        .req_tgl_async (req_tgl),
        .src_addr      (tgt_addr),
        .src_en        (tgt_en),
        .src_wdata     (tgt_wdata),
        .bus_strobe    (rtc_strobe),
        .bus_write     (rtc_write),
        .bus_be        (rtc_be),
        .bus_addr      (rtc_addr),
        .bus_wdata     (rtc_wdata),
        .bus_rdata     (rtc_rdata),
        .rd_hold       (rd_hold),
        .ack_tgl       (ack_tgl)
    );
endmodule

// File: tb/test_xdom_reg_bridge.sv
module test_xdom_reg_bridge;
    logic        cpu_clk = 1'b0, rtc_clk = 1'b0;
    logic        cpu_rst_n = 1'b0, rtc_rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        rtc_strobe, rtc_write;
    logic [3:0]  rtc_be;
    logic [15:0] rtc_addr;
    logic [31:0] rtc_wdata, rtc_rdata;

    int checks = 0, errors = 0;
    int strobe_cnt = 0, double_cnt = 0;
    logic strobe_prev = 1'b0;
    logic [31:0] mem [16];

    always #5 cpu_clk = ~cpu_clk;
    always #19 rtc_clk = ~rtc_clk;

    xdom_reg_bridge i_xdom_reg_bridge (.*);

    // Slow-domain register file model
    assign rtc_rdata = mem[rtc_addr[3:0]];
    always @(posedge rtc_clk) begin
        if (rtc_strobe) begin
            strobe_cnt <= strobe_cnt + 1;
            if (rtc_write)
                for (int b = 0; b < 4; b++)
                    if (rtc_be[b]) mem[rtc_addr[3:0]][8*b +: 8] <= rtc_wdata[8*b +: 8];
        end
        if (rtc_strobe && strobe_prev) double_cnt <= double_cnt + 1;
        strobe_prev <= rtc_strobe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge cpu_clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge cpu_clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        cpu_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            reg_rd(4'h0, v);
            if (v == 0) return;
        end
        chk("R3 busy timeout", v, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(4'h0, v); chk("R1 ctrl after reset", v, 0);
        reg_rd(4'hC, v); chk("R1 data after reset", v, 0);
        chk("R1 no strobe", strobe_cnt, 0);
    endtask

    task automatic t_stage_order();
        logic [31:0] v;
        reg_wr(4'hC, 32'hCAFE_0001);
        reg_wr(4'h8, 32'h0000_0003);
        reg_wr(4'h4, 32'h0000_00F1);
        reg_rd(4'h4, v); chk("R7 enable readback", v, 32'hF1);
        reg_rd(4'h8, v); chk("R7 address readback", v, 32'h3);
        reg_rd(4'hC, v); chk("R7 data readback", v, 32'hCAFE_0001);
    endtask

    task automatic t_full_write();
        logic [31:0] v;
        int s0 = strobe_cnt;
        reg_wr(4'h0, 32'h1);
        reg_rd(4'h0, v); chk("R3 busy while in flight", v, 1);
        wait_idle();
        chk("R5 full write", mem[3], 32'hCAFE_0001);
        chk("R2 one access per start", strobe_cnt - s0, 1);
    endtask

    task automatic t_read(input logic [3:0] a, input logic [31:0] val);
        logic [31:0] v;
        mem[a] = val;
        reg_wr(4'h4, 32'h0);
        reg_wr(4'h8, {28'h0, a});
        reg_wr(4'h0, 32'h1);
        wait_idle();
        reg_rd(4'hC, v); chk("R4 R10 read data at idle", v, val);
    endtask

    task automatic t_byte_write();
        mem[7] = 32'hAABB_CCDD;
        reg_wr(4'h8, 32'h7);
        reg_wr(4'hC, 32'h1122_3344);
        reg_wr(4'h4, 32'h51);   // write flag, lanes 0 and 2
        reg_wr(4'h0, 32'h1);
        wait_idle();
        chk("R6 partial byte write", mem[7], 32'hAA22_CC44);
    endtask

    task automatic t_busy_writes();
        logic [31:0] v;
        int s0 = strobe_cnt;
        mem[5] = 32'h1234_5678;
        mem[9] = 32'h9999_9999;
        reg_wr(4'h4, 32'h0);
        reg_wr(4'h8, 32'h5);
        reg_wr(4'h0, 32'h1);
        reg_wr(4'h0, 32'h1);          // R8 ignored start
        reg_wr(4'h8, 32'h9);          // R9 ignored staging
        reg_wr(4'h4, 32'hF1);
        wait_idle();
        repeat (40) @(negedge cpu_clk);
        chk("R8 no extra access", strobe_cnt - s0, 1);
        reg_rd(4'hC, v); chk("R8 transfer result", v, 32'h1234_5678);
        reg_rd(4'h8, v); chk("R9 address held", v, 32'h5);
        reg_rd(4'h4, v); chk("R9 enable held", v, 32'h0);
        chk("R9 target untouched", mem[9], 32'h9999_9999);
    endtask

    task automatic t_zero_ctrl();
        logic [31:0] v;
        int s0 = strobe_cnt;
        reg_wr(4'h0, 32'hFFFF_FFFE);
        reg_rd(4'h0, v); chk("R11 ctrl stays idle", v, 0);
        repeat (40) @(negedge cpu_clk);
        chk("R11 no access", strobe_cnt - s0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge cpu_clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        repeat (4) @(posedge rtc_clk);
        @(negedge cpu_clk); cpu_rst_n = 1'b1;
        @(negedge rtc_clk); rtc_rst_n = 1'b1;
        repeat (20) @(negedge cpu_clk);
        t_reset();
        t_stage_order();
        t_full_write();
        t_read(4'h5, 32'h1234_5678);
        t_read(4'hA, 32'h8000_0001);
        t_read(4'h3, 32'hCAFE_0001);
        t_byte_write();
        t_busy_writes();
        t_zero_ctrl();
        chk("R12 single-cycle strobe", double_cnt, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule